// File: doc/BRIEF.md
# Serial Configuration Load Sequencer

This block runs once after every reset and brings in the device configuration as a serial bit stream. During the first clock after reset is released it samples two strap pins. One selects whether the block drives the serial clock itself, as the system clock divided by a power of two, or follows an externally supplied serial clock. The other sets the active polarity of the downstream local-address output enable. The first serial bit received picks the configuration source: a 0 means a local serial memory, a 1 means loading over the backplane. The active-low memory enable stays asserted while a local load is running.

After the last configuration bit, the sequencer loads two external address-match registers: first the mask, then the compare. It steers a select line and issues one strobe pulse per register, holding the memory enable and the latch-data enable low throughout. It then raises a done flag and releases the shared pins to their normal function. Configuration bits leave the block as a one-bit stream that is valid for one cycle and has no ready. The serial source cannot be paused, so a consumer must accept every bit on the cycle it is marked valid. No back-pressure exists. While reset is low, a drive-enable output is low so that pad logic can tri-state the pins. It stays low until the first rising clock edge after release.

Top module: `cfg_loader_seq`

## Requirements
- R1: `drive_en_o` is 0 while `rst_n` is 0, and it is 1 from the first rising clock edge after `rst_n` goes high.
- R2: If `strap_sclk_i` was 1 at the first edge after reset, `sclk_oe_o` is 1 while bits are being received, and `sclk_o` has a period of 2**DIV_LOG2 system clocks. If the strap was 0, `sclk_oe_o` stays 0.
- R3: `src_bus_o` equals the first serial bit sampled (1 = backplane, 0 = local memory).
- R4: `prom_en_n_o` is 0 from reset until the source bit is sampled. It stays 0 while a local load is receiving bits and is 1 while a backplane load is receiving bits.
- R5: `aen_act_low_o` equals `strap_aen_i` as sampled at the first edge after reset (1 = active-low enable, 0 = active-high), and it holds that value until the next reset.
- R6: Each of the CFG_BITS bits that follow the source bit appears once on `cfg_bit_o`, in arrival order, with `cfg_bit_vld_o` high for exactly one cycle.
- R7: After the last bit, there is exactly one strobe pulse with `sel_o`=0 (mask) and then exactly one with `sel_o`=1 (compare). During each strobe, `prom_en_n_o` and `ldata_en_n_o` are both 0.
- R8: `done_o` rises 4 cycles after the last `cfg_bit_vld_o` and then stays 1. While it is 1, `prom_en_n_o`=1, `ldata_en_n_o`=1, `strobe_o`=0 and `sclk_oe_o`=0.
- R9: A reset in the middle of a load abandons it: `done_o` clears, the straps are sampled again, and the next load starts over from the source bit.
- R10: In external-clock mode, a data bit is taken on each rising edge of `sclk_ext_i` after that edge has been synchronised to `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on or system) |
| strap_sclk_i | input | 1 | Strap: 1 = drive serial clock, 0 = accept external clock |
| strap_aen_i | input | 1 | Strap: 1 = address enable active-low, 0 = active-high |
| sclk_ext_i | input | 1 | External serial clock |
| sdata_i | input | 1 | Serial configuration data |
| drive_en_o | output | 1 | Pad drive enable, low during reset |
| sclk_o | output | 1 | Generated serial clock |
| sclk_oe_o | output | 1 | Output enable for the serial clock pin |
| prom_en_n_o | output | 1 | Active-low serial memory enable |
| ldata_en_n_o | output | 1 | Active-low latch-data enable |
| strobe_o | output | 1 | Register load strobe |
| sel_o | output | 1 | Register select: 0 = mask, 1 = compare |
| aen_act_low_o | output | 1 | Sampled address-enable polarity |
| src_bus_o | output | 1 | Configuration source: 1 = backplane |
| cfg_bit_o | output | 1 | Received configuration bit |
| cfg_bit_vld_o | output | 1 | Valid for `cfg_bit_o`, one-cycle pulse |
| done_o | output | 1 | Load sequence complete |

## Verification
The hardest case to reach is a reset that arrives in the middle of a load. The straps must then be sampled again, and no strobe or done may come from the abandoned load. The stimulus gets there by starting a load with one strap setting and asserting reset after a few bits have been received. It then runs a full load with the other polarity strap and checks the new polarity and a clean strobe sequence. External-clock mode is reached by driving a slow clock on `sclk_ext_i` whose edges land several system cycles apart. Every strap and source combination is swept in both clock modes.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    ST_STRAP,
    ST_SEL,
    ST_LOAD,
    ST_MSET,
    ST_MSTB,
    ST_CSET,
    ST_CSTB,
    ST_DONE
  } ld_state_e;
endpackage

// File: rtl/cfg_sclk_unit.sv
// Serial clock: internal divider or synchronised external clock, one tick per rising edge.
module cfg_sclk_unit #(
  parameter int DIV_LOG2 = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic use_int,
  input  logic sclk_ext_i,
  output logic sclk_raw_o,
  output logic tick_o
);
  localparam logic [DIV_LOG2-1:0] RISE_AT = DIV_LOG2'((1 << (DIV_LOG2 - 1)) - 1);

  logic [DIV_LOG2-1:0] div_q;
  logic [2:0]          sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (run && use_int) begin
      div_q <= div_q + 1'b1;
    end else begin
      div_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], sclk_ext_i};
    end
  end

  assign sclk_raw_o = div_q[DIV_LOG2-1];
  assign tick_o = run && (use_int ? (div_q == RISE_AT) : (sync_q[1] && !sync_q[2]));
endmodule

// File: rtl/cfg_bit_counter.sv
// Counts received configuration bits and flags the last one.
module cfg_bit_counter #(
  parameter int NBITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last_o
);
  localparam int CW = $clog2(NBITS + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(NBITS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = inc && (cnt_q == LAST_IDX);
endmodule

// File: rtl/cfg_loader_seq.sv
module cfg_loader_seq
  import cfg_loader_pkg::*;
#(
  parameter int CFG_BITS = 16,
  parameter int DIV_LOG2 = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_sclk_i,
  input  logic strap_aen_i,
  input  logic sclk_ext_i,
  input  logic sdata_i,
  output logic drive_en_o,
  output logic sclk_o,
  output logic sclk_oe_o,
  output logic prom_en_n_o,
  output logic ldata_en_n_o,
  output logic strobe_o,
  output logic sel_o,
  output logic aen_act_low_o,
  output logic src_bus_o,
  output logic cfg_bit_o,
  output logic cfg_bit_vld_o,
  output logic done_o
);
  ld_state_e st_q, st_d;
  logic      int_q, aen_q, src_q, drv_q, bit_q, vld_q;
  logic      run, tick, last, sclk_raw, in_load, reg_phase;

  assign run       = (st_q == ST_SEL) || (st_q == ST_LOAD);
  assign in_load   = (st_q == ST_LOAD);
  assign reg_phase = (st_q == ST_MSET) || (st_q == ST_MSTB) ||
                     (st_q == ST_CSET) || (st_q == ST_CSTB);

  cfg_sclk_unit #(.DIV_LOG2(DIV_LOG2)) u_sclk (
    .clk(clk), .rst_n(rst_n), .run(run), .use_int(int_q),
    .sclk_ext_i(sclk_ext_i), .sclk_raw_o(sclk_raw), .tick_o(tick)
  );

  cfg_bit_counter #(.NBITS(CFG_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(st_q == ST_SEL),
    .inc(in_load && tick), .last_o(last)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_STRAP: st_d = ST_SEL;
      ST_SEL:   if (tick) st_d = ST_LOAD;
      ST_LOAD:  if (last) st_d = ST_MSET;
      ST_MSET:  st_d = ST_MSTB;
      ST_MSTB:  st_d = ST_CSET;
      ST_CSET:  st_d = ST_CSTB;
      ST_CSTB:  st_d = ST_DONE;
      default:  st_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_STRAP;
      int_q <= 1'b0;
      aen_q <= 1'b0;
      src_q <= 1'b0;
      drv_q <= 1'b0;
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      drv_q <= 1'b1;
      vld_q <= in_load && tick;
      if (st_q == ST_STRAP) begin
        int_q <= strap_sclk_i;
        aen_q <= strap_aen_i;
      end
      if (st_q == ST_SEL && tick) src_q <= sdata_i;
      if (in_load && tick) bit_q <= sdata_i;
    end
  end

  assign drive_en_o    = drv_q;
  assign sclk_o        = int_q && sclk_raw;
  assign sclk_oe_o     = int_q && run;
  assign prom_en_n_o   = !((st_q == ST_STRAP) || (st_q == ST_SEL) || reg_phase ||
                           (in_load && !src_q));
  assign ldata_en_n_o  = !reg_phase;
  assign strobe_o      = (st_q == ST_MSTB) || (st_q == ST_CSTB);
  assign sel_o         = (st_q == ST_CSET) || (st_q == ST_CSTB);
  assign aen_act_low_o = aen_q;
  assign src_bus_o     = src_q;
  assign cfg_bit_o     = bit_q;
  assign cfg_bit_vld_o = vld_q;
  assign done_o        = (st_q == ST_DONE);
endmodule

// File: rtl/cfg_loader_seq_chk.sv
module cfg_loader_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic in_load,
  input logic drive_en_o,
  input logic sclk_oe_o,
  input logic prom_en_n_o,
  input logic ldata_en_n_o,
  input logic strobe_o,
  input logic aen_act_low_o,
  input logic src_bus_o,
  input logic cfg_bit_vld_o,
  input logic done_o
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_no_drive_in_reset: assert (!drive_en_o);
    end
  end

  a_r4_prom_follows_source: assert property (@(posedge clk) disable iff (!rst_n)
    in_load |-> (prom_en_n_o == src_bus_o));

  a_r5_polarity_held: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en_o && $past(drive_en_o)) |-> $stable(aen_act_low_o));

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bit_vld_o |=> !cfg_bit_vld_o);

  a_r7_strobe_enables: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> (!ldata_en_n_o && !prom_en_n_o));

  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (prom_en_n_o && ldata_en_n_o && !strobe_o && !sclk_oe_o));
endmodule

bind cfg_loader_seq cfg_loader_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_load(in_load), .drive_en_o(drive_en_o),
  .sclk_oe_o(sclk_oe_o), .prom_en_n_o(prom_en_n_o), .ldata_en_n_o(ldata_en_n_o),
  .strobe_o(strobe_o), .aen_act_low_o(aen_act_low_o), .src_bus_o(src_bus_o),
  .cfg_bit_vld_o(cfg_bit_vld_o), .done_o(done_o)
);

// File: tb/cfg_loader_seq_tb.sv
module cfg_loader_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 6;
  localparam int DIVL = 2;

  logic clk = 1'b0;
  logic rst_n, strap_sclk, strap_aen, sclk_ext, sdata;
  logic drive_en, sclk, sclk_oe, prom_en_n, ldata_en_n, strobe, sel;
  logic aen_low, src_bus, cfg_bit, cfg_vld, done;

  int checks = 0, fails = 0, cyc = 0;
  bit in_run = 0, exp_src = 0, sclk_prev = 0, rise_seen = 0, done_seen = 0;
  int rx_n = 0, stb_n = 0, last_rise = 0, last_vld = 0, done_cyc = 0;
  logic [NB-1:0] rx_bits;
  logic [1:0]    stb_sel;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cfg_loader_seq #(.CFG_BITS(NB), .DIV_LOG2(DIVL)) dut_i (
    .clk(clk), .rst_n(rst_n), .strap_sclk_i(strap_sclk), .strap_aen_i(strap_aen),
    .sclk_ext_i(sclk_ext), .sdata_i(sdata), .drive_en_o(drive_en), .sclk_o(sclk),
    .sclk_oe_o(sclk_oe), .prom_en_n_o(prom_en_n), .ldata_en_n_o(ldata_en_n),
    .strobe_o(strobe), .sel_o(sel), .aen_act_low_o(aen_low), .src_bus_o(src_bus),
    .cfg_bit_o(cfg_bit), .cfg_bit_vld_o(cfg_vld), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (in_run) begin
      if (cfg_vld) begin
        if (rx_n < NB) rx_bits[rx_n] = cfg_bit;
        if (rx_n < NB - 1) chk(prom_en_n == exp_src, "R4 prom enable during bits", prom_en_n, exp_src);
        rx_n++;
        last_vld = cyc;
      end
      if (strobe) begin
        if (stb_n < 2) stb_sel[stb_n] = sel;
        chk(!ldata_en_n && !prom_en_n, "R7 enables low at strobe", {ldata_en_n, prom_en_n}, 0);
        stb_n++;
      end
      if (done && !done_seen) begin
        done_seen = 1;
        done_cyc  = cyc;
      end
      if (sclk && !sclk_prev) begin
        if (rise_seen) chk(cyc - last_rise == (1 << DIVL), "R2 sclk period", cyc - last_rise, 1 << DIVL);
        last_rise = cyc;
        rise_seen = 1;
      end
      sclk_prev = sclk;
    end
  end

  task automatic run_load(input bit ic, input bit ae, input bit sb, input logic [NB-1:0] pat,
                          input int abort_at);
    in_run = 0; rst_n = 1'b0; strap_sclk = ic; strap_aen = ae; sdata = 1'b0; sclk_ext = 1'b0;
    rx_n = 0; stb_n = 0; rise_seen = 0; sclk_prev = 0; done_seen = 0; rx_bits = '0; stb_sel = '0;
    repeat (3) @(negedge clk);
    chk(drive_en == 1'b0, "R1 drive off in reset", drive_en, 0);
    chk(prom_en_n == 1'b0 && done == 1'b0, "R4 reset state", {prom_en_n, done}, 0);
    sdata = sb; rst_n = 1'b1; exp_src = sb;
    @(negedge clk);
    chk(drive_en == 1'b1, "R1 drive on after first edge", drive_en, 1);
    chk(aen_low == ae, "R5 polarity strap", aen_low, ae);
    chk(sclk_oe == ic, "R2 clock direction", sclk_oe, ic);
    in_run = 1;
    for (int b = 0; b <= NB; b++) begin
      sdata = (b == 0) ? sb : pat[b-1];
      if (abort_at > 0 && b == abort_at) begin
        rst_n = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && drive_en == 1'b0, "R9 reset mid-load", {done, drive_en}, 0);
        chk(stb_n == 0, "R9 no strobe from aborted load", stb_n, 0);
        in_run = 0;
        return;
      end
      if (ic) begin
        @(posedge sclk);
        @(negedge sclk);
        #1;
      end else begin
        repeat (3) @(negedge clk);
        sclk_ext = 1'b1;
        repeat (4) @(negedge clk);
        sclk_ext = 1'b0;
        @(negedge clk);
      end
    end
    for (int k = 0; k < 40 && !done_seen; k++) @(negedge clk);
    chk(done == 1'b1, "R8 done raised", done, 1);
    chk(src_bus == sb, "R3 source bit", src_bus, sb);
    chk(rx_n == NB, "R6 bit count", rx_n, NB);
    if (ic) chk(rx_bits == pat, "R6 bit order (internal clock)", rx_bits, pat);
    else    chk(rx_bits == pat, "R10 bits on external clock edges", rx_bits, pat);
    chk(stb_n == 2 && stb_sel == 2'b10, "R7 mask then compare", {stb_n[1:0], stb_sel}, 4'b1010);
    chk(done_cyc - last_vld == 4, "R8 done latency", done_cyc - last_vld, 4);
    repeat (3) @(negedge clk);
    chk(done && prom_en_n && ldata_en_n && !strobe && !sclk_oe, "R8 quiet after done",
        {done, prom_en_n, ldata_en_n, strobe, sclk_oe}, 5'b11100);
    chk(aen_low == ae, "R5 polarity held", aen_low, ae);
    in_run = 0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired actual=0 expected=1");
    finish_up();
  end

  initial begin
    rst_n = 1'b0;
    strap_sclk = 1'b0; strap_aen = 1'b0; sclk_ext = 1'b0; sdata = 1'b0;
    for (int ic = 0; ic < 2; ic++)
      for (int ae = 0; ae < 2; ae++)
        for (int sb = 0; sb < 2; sb++)
          for (int p = 0; p < 3; p++)
            run_load(ic[0], ae[0], sb[0], (p == 0) ? 6'h2A : (p == 1) ? 6'h15 : 6'h31, 0);
    run_load(1'b1, 1'b1, 1'b0, 6'h0F, 3);
    run_load(1'b1, 1'b0, 1'b0, 6'h33, 0);
    run_load(1'b0, 1'b1, 1'b1, 6'h1C, 2);
    run_load(1'b0, 1'b0, 1'b1, 6'h27, 0);
    finish_up();
  end
endmodule